// File: doc/BRIEF.md
# Dual-Edge Serial Clock Counter

This block is a small wrap-around event counter meant to sit beside a shift-based serial port and count its clock events. Each clock cycle it advances by one when the selected source fires. There are three sources: both edges of an external serial clock pin, a one-cycle overflow pulse from a neighbouring timer, or a software strobe. When the count wraps from all ones to zero, a sticky overflow flag is set. The flag drives an interrupt output through an enable, and a one-cycle carry pulse lets an 8-bit timer take the carry and extend the count to 12 bits.

Software can load any count value at any time. Loading the all-ones value turns the counter into an edge-triggered interrupt source. With the pin selected, the very next pin transition in either direction overflows it and raises the interrupt. With the strobe selected, a single strobe does the same and so acts as a software interrupt. The external pin is asynchronous to the system clock and is brought in through a flop synchronizer. The synchronizer starts at the low level after reset.

Top module: `dual_edge_counter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cnt_o` is 0 and `flag_o`, `irq_o` and `carry_o` are 0.
- R2: With `src_sel_i` = 2'b01 (pin), every rising edge and every falling edge of `pin_i` adds one to `cnt_o`. The new count is visible three clock cycles after the pin changes and not before. Each edge adds exactly once.
- R3: With `src_sel_i` = 2'b10 (timer), each cycle that `tmr_ovf_i` is high adds one to `cnt_o`, visible in the next cycle.
- R4: With `src_sel_i` = 2'b11 (software), each cycle that `sw_strobe_i` is high adds one to `cnt_o`, visible in the next cycle.
- R5: Sources other than the selected one have no effect on `cnt_o`. With `src_sel_i` = 2'b00 (off), nothing advances the count.
- R6: When `cnt_we_i` is high, `cnt_o` takes `cnt_wdata_i` in the next cycle, even if an increment fires in the same cycle. A load never sets the flag or the carry.
- R7: An increment at 0xF makes `cnt_o` 0x0. In that same next cycle `carry_o` is high for exactly one cycle and `flag_o` is set.
- R8: `flag_o` stays set until a cycle with `flag_clr_i` high, and clears in the next cycle. If a wrap and a clear happen in the same cycle, the flag stays set.
- R9: `irq_o` is a register loaded each cycle with the new flag value ANDed with `irq_en_i`. A change of `irq_en_i` therefore reaches `irq_o` one cycle later.
- R10: After a load of 0xF with the pin selected, a single pin edge of either direction raises `flag_o` and, when enabled, `irq_o`.
- R11: After a load of 0xF with the software source selected, a single strobe raises `flag_o` and, when enabled, `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_i | input | 2 | Source: 00 off, 01 pin edges, 10 timer pulse, 11 software strobe |
| pin_i | input | 1 | Asynchronous external serial clock pin |
| tmr_ovf_i | input | 1 | One-cycle overflow pulse from a timer |
| sw_strobe_i | input | 1 | Software clock strobe |
| cnt_we_i | input | 1 | Load strobe for the count |
| cnt_wdata_i | input | CNT_W | Value to load |
| flag_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_o | output | CNT_W | Current count |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Registered interrupt request |
| carry_o | output | 1 | One-cycle pulse on each wrap, for cascading |

## Verification
Strobe, timer pulse, load, flag clear and enable changes all take effect one clock after the cycle in which they are driven. Pin transitions take three clocks because of the two synchronizer flops and the edge compare. For every stimulus the driver records the clock number at which the result is due. For a pin edge it also records the clock before that, where the count must still be unchanged. The monitor compares each item in the cycle it is due, at the falling clock edge. Idle cycles placed after each wrap check that the carry has dropped and that the flag and interrupt are held.

// File: rtl/dual_edge_counter_pkg.sv
package dual_edge_counter_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_PIN = 2'b01,
    SRC_TMR = 2'b10,
    SRC_SW  = 2'b11
  } src_e;
endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[gi] <= 1'b0;
        else     sync_q[gi] <= sync_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  // either direction of transition gives a single-cycle pulse
  assign edge_o = sync_q[LAST] ^ prev_q;
endmodule

// File: rtl/tick_select.sv
module tick_select
  import dual_edge_counter_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       pin_edge_i,
  input  logic       tmr_ovf_i,
  input  logic       sw_strobe_i,
  output logic       tick_o
);
  src_e sel;
  assign sel = src_e'(sel_i);

  always_comb begin
    case (sel)
      SRC_PIN: tick_o = pin_edge_i;
      SRC_TMR: tick_o = tmr_ovf_i;
      SRC_SW:  tick_o = sw_strobe_i;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             carry_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic inc;
  assign inc    = tick_i && !we_i;
  assign wrap_o = inc && (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      carry_o <= wrap_o;
      if (we_i)     cnt_o <= wdata_i;
      else if (inc) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ovf_flag_ctl.sv
module ovf_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_nxt;

  always_comb begin
    if (wrap_i)     flag_nxt = 1'b1;
    else if (clr_i) flag_nxt = 1'b0;
    else            flag_nxt = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_nxt;
      irq_o  <= flag_nxt && ie_i;
    end
  end
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel_i,
  input  logic             pin_i,
  input  logic             tmr_ovf_i,
  input  logic             sw_strobe_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             carry_o
);
  logic pin_edge;
  logic tick;
  logic wrap;

  pin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .edge_o (pin_edge)
  );

  tick_select u_sel (
    .sel_i       (src_sel_i),
    .pin_edge_i  (pin_edge),
    .tmr_ovf_i   (tmr_ovf_i),
    .sw_strobe_i (sw_strobe_i),
    .tick_o      (tick)
  );

  wrap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap),
    .carry_o (carry_o)
  );

  ovf_flag_ctl u_flag (
    .clk    (clk),
    .rst    (rst),
    .wrap_i (wrap),
    .clr_i  (flag_clr_i),
    .ie_i   (irq_en_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/dual_edge_counter_chk.sv
module dual_edge_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       src_sel_i,
  input logic             cnt_we_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             flag_clr_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             carry_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (cnt_o == '0 && !flag_o && !irq_o && !carry_o));

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !cnt_we_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick && !cnt_we_i |=> $stable(cnt_o));

  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    src_sel_i == 2'b00 && !cnt_we_i |=> $stable(cnt_o));

  // R6
  load_prio_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we_i |=> cnt_o == $past(cnt_wdata_i) && !carry_o);

  // R7
  wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !cnt_we_i && cnt_o == CNT_MAX |=> carry_o && flag_o && cnt_o == '0);

  // R7
  carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> cnt_o == '0 && flag_o);

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> carry_o);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_o && !flag_clr_i |=> flag_o);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_o && $past(irq_en_i)));
endmodule

bind dual_edge_counter dual_edge_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .src_sel_i   (src_sel_i),
  .cnt_we_i    (cnt_we_i),
  .cnt_wdata_i (cnt_wdata_i),
  .flag_clr_i  (flag_clr_i),
  .irq_en_i    (irq_en_i),
  .cnt_o       (cnt_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .carry_o     (carry_o)
);

// File: tb/tb_dual_edge_counter.sv
module tb_dual_edge_counter;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       src_sel_i = 2'b11;
  logic             pin_i = 1'b0;
  logic             tmr_ovf_i = 1'b0;
  logic             sw_strobe_i = 1'b0;
  logic             cnt_we_i = 1'b0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic             flag_clr_i = 1'b0;
  logic             irq_en_i = 1'b1;
  logic [CNT_W-1:0] cnt_o;
  logic             flag_o, irq_o, carry_o;

  dual_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .src_sel_i(src_sel_i), .pin_i(pin_i),
    .tmr_ovf_i(tmr_ovf_i), .sw_strobe_i(sw_strobe_i), .cnt_we_i(cnt_we_i),
    .cnt_wdata_i(cnt_wdata_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o), .carry_o(carry_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int               due;
    logic [CNT_W-1:0] cnt;
    bit               flag;
    bit               irq;
    bit               carry;
    string            tag;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   checks = 0;
  int   fails  = 0;

  // reference model state
  logic [CNT_W-1:0] m_cnt  = '0;
  bit               m_flag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_exp(input int due, input bit carry, input string tag);
    exp_t e;
    e.due = due; e.cnt = m_cnt; e.flag = m_flag;
    e.irq = m_flag && irq_en_i; e.carry = carry; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_step(input bit tick, input bit we, input logic [CNT_W-1:0] wd,
                            input bit clr, output bit wrap);
    wrap = tick && !we && (m_cnt == {CNT_W{1'b1}});
    if (we)        m_cnt = wd;
    else if (tick) m_cnt = m_cnt + 1'b1;
    if (wrap)      m_flag = 1'b1;
    else if (clr)  m_flag = 1'b0;
  endtask

  // one-cycle stimulus; tick says whether the selected source fires
  task automatic drive(input bit strb, input bit tmr, input bit we,
                       input logic [CNT_W-1:0] wd, input bit clr,
                       input bit tick, input string tag);
    bit wrap;
    sw_strobe_i = strb; tmr_ovf_i = tmr; cnt_we_i = we;
    cnt_wdata_i = wd; flag_clr_i = clr;
    model_step(tick, we, wd, clr, wrap);
    push_exp(cyc + 1, wrap, tag);
    @(negedge clk);
    sw_strobe_i = 1'b0; tmr_ovf_i = 1'b0; cnt_we_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  // pin toggle: unchanged two clocks later, counted on the third
  task automatic pin_toggle(input bit counts, input string tag);
    bit wrap;
    pin_i = ~pin_i;
    push_exp(cyc + 2, 1'b0, tag);
    model_step(counts, 1'b0, '0, 1'b0, wrap);
    push_exp(cyc + 3, wrap, tag);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare each item at the negedge of its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc || cnt_o !== e.cnt || flag_o !== e.flag ||
          irq_o !== e.irq || carry_o !== e.carry) begin
        fails++;
        $display("FAIL %s cyc=%0d cnt=%h exp %h flag=%b exp %b irq=%b exp %b carry=%b exp %b",
                 e.tag, cyc, cnt_o, e.cnt, flag_o, e.flag, irq_o, e.irq, carry_o, e.carry);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, during reset and first cycle after release
    checks++;
    if (cnt_o !== '0 || flag_o || irq_o || carry_o) begin
      fails++;
      $display("FAIL R1 in reset cnt=%h flag=%b irq=%b carry=%b exp 0", cnt_o, flag_o, irq_o, carry_o);
    end
    rst = 1'b0;
    idle("R1");

    // R4: software strobe
    src_sel_i = 2'b11;
    repeat (3) drive(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R4");
    // R6: load wins over a simultaneous strobe
    drive(1'b1, 1'b0, 1'b1, 4'hE, 1'b0, 1'b1, "R6");
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R4");
    // R7 / R11: wrap from F by strobe
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R7_R11");
    idle("R7");
    idle("R8");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R8");
    // R6: load of F never sets flag
    drive(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, "R6");

    // R3: timer source; R5: strobe ignored here
    src_sel_i = 2'b10;
    drive(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1, "R3");
    drive(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1, "R3");
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5");
    idle("R8");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R8");

    // R5: source off
    src_sel_i = 2'b00;
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R5");
    pin_toggle(1'b0, "R5");

    // R9 / R8: disabled interrupt, set beats clear
    irq_en_i = 1'b0;
    src_sel_i = 2'b11;
    drive(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, "R6");
    drive(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R8_R9");
    idle("R9");
    irq_en_i = 1'b1;
    idle("R9");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R8");

    // R2 / R10: pin both edges, preloaded F acts as edge interrupt
    src_sel_i = 2'b01;
    drive(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, "R6");
    pin_toggle(1'b1, "R2_R10");
    idle("R7");
    pin_toggle(1'b1, "R2");
    pin_toggle(1'b1, "R2");
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R5");
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R8");
    idle("R2");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard %0d items never compared", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule